// File: doc/BRIEF.md
# Soft-Start Ramp and Overload Trip Controller

This block sets the cycle-by-cycle drain current-limit for a current-mode switching converter controller and decides when a sustained overload must shut the converter down. Each start or restart after a fault strobes `start_i`. The block then raises a digital current-limit code from zero to full scale in equal steps of a fixed duration. The downstream peak-current comparator uses that code as its threshold.

Once the ramp ends, the block watches every switching cycle. A saturating up/down counter counts cycles that the overcurrent comparator ended. It steps up on each such cycle and steps down on each clean one, so a short or intermittent overload decays and does not build up. When the counter reaches its end of count, the block emits a one-clock trip pulse. A second timer covers a converter held at its minimum switching frequency. It trips after a maximum delay that scales with the selected frequency option. A trip forces the current-limit code to zero until the next start strobe. The wait before restarting is handled outside this block.

Top module: `ovl_ss_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start strobe, `ilim_code_o` is 0, `ss_active_o` is 0 and `trip_o` is 0.
- R2: A clock edge with `start_i` high sets `ilim_code_o` to 0 and `ss_active_o` to 1. It has priority over every other input and over any pending trip.
- R3: While soft-start is active, `ilim_code_o` rises by exactly one every `STEP_CYC` clocks. On the edge where it reaches `SS_STEPS`, `ss_active_o` falls, and the code then holds at `SS_STEPS`.
- R4: While `ss_active_o` is high, overcurrent-ended cycles and the minimum-frequency flag have no effect: the overload counter holds its value, the minimum-frequency timer stays at zero, and no trip occurs.
- R5: `ocp_end_i` is sampled only on edges where `cyc_i` is high. Each such cycle with `ocp_end_i`=1 increments the overload counter. The cycle that would reach `OVL_TERM` produces a trip.
- R6: Each `cyc_i` edge with `ocp_end_i`=0 decrements the overload counter. The counter saturates at zero, so clean cycles never leave credit that allows more than `OVL_TERM` overcurrent cycles before a trip.
- R7: With `at_fmin_i` continuously high outside soft-start, a trip occurs after `FMIN_BASE << k` clocks. Here k is `fopt_i` for codes 0, 1 and 2, and code 3 acts as code 2.
- R8: Any clock with `at_fmin_i` low clears the minimum-frequency timer.
- R9: A trip shows as `trip_o` high for exactly one clock. During that clock `ilim_code_o` is 0 and `ss_active_o` is 0. The overload counter and the minimum-frequency timer are both cleared.
- R10: `start_i` clears the overload counter and the minimum-frequency timer, so a partial count from before the strobe never shortens the next trip delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/restart strobe, one clock |
| cyc_i | input | 1 | End-of-switching-cycle strobe |
| ocp_end_i | input | 1 | Cycle was ended by the overcurrent comparator (valid with cyc_i) |
| at_fmin_i | input | 1 | Converter is running at minimum switching frequency |
| fopt_i | input | 2 | Frequency option: 0 base delay, 1 double, 2 and 3 quadruple |
| ilim_code_o | output | $clog2(SS_STEPS+1) | Current-limit step code, 0 to SS_STEPS |
| ss_active_o | output | 1 | Soft-start ramp in progress |
| trip_o | output | 1 | Overload trip pulse |

## Verification
Every result is registered, so a change on `start_i`, `cyc_i`/`ocp_end_i` or `at_fmin_i` sampled at one edge appears on the outputs right after that same edge. The ramp code moves `STEP_CYC` edges after the start edge. The overload trip shows one clock after the `OVL_TERM`-th net overcurrent cycle. The minimum-frequency trip shows `FMIN_BASE << k` edges after the flag rises. The bench drives inputs and compares outputs on the falling edge. Its behavioural model advances on the same rising edges as the design, so each expected value lands in the exact cycle the design must produce it. Directed checks then count trip pulses over whole stimulus windows to confirm the ignored and decaying cases.

// File: rtl/ovl_ss_pkg.sv
package ovl_ss_pkg;
  typedef enum logic [1:0] {
    FOPT_X1  = 2'd0,
    FOPT_X2  = 2'd1,
    FOPT_X4  = 2'd2,
    FOPT_X4B = 2'd3
  } fopt_e;

  function automatic int unsigned fmin_shift(input logic [1:0] sel);
    case (fopt_e'(sel))
      FOPT_X1: return 0;
      FOPT_X2: return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int STEP_CYC = 100000,
  parameter int SS_STEPS = 8,
  parameter int CODE_W   = $clog2(SS_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kill_i,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o
);
  localparam int TMR_W = $clog2(STEP_CYC + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(SS_STEPS);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q    <= '0;
      code_o   <= '0;
      active_o <= 1'b0;
    end else if (start_i) begin
      tmr_q    <= '0;
      code_o   <= '0;
      active_o <= 1'b1;
    end else if (kill_i) begin
      tmr_q    <= '0;
      code_o   <= '0;
      active_o <= 1'b0;
    end else if (active_o) begin
      if (tmr_q == TMR_LAST) begin
        tmr_q  <= '0;
        code_o <= code_o + 1'b1;
        if (code_o + 1'b1 == CODE_TOP) active_o <= 1'b0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_updown.sv
module ovl_updown #(
  parameter int OVL_TERM = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic cyc_i,
  input  logic ocp_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(OVL_TERM + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVL_TERM - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bump;

  assign bump  = en_i & cyc_i;
  assign hit_o = bump & ocp_i & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (bump) begin
      if (ocp_i)              cnt_q <= cnt_q + 1'b1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fmin_timer.sv
module fmin_timer
  import ovl_ss_pkg::*;
#(
  parameter int FMIN_BASE = 10000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] fopt_i,
  output logic       hit_o
);
  localparam int TMR_W = $clog2(FMIN_BASE * 4 + 1);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] lim_last;

  assign lim_last = (TMR_W'(FMIN_BASE) << fmin_shift(fopt_i)) - 1'b1;
  assign hit_o    = run_i & (tmr_q >= lim_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tmr_q <= '0;
    else if (clr_i || !run_i)    tmr_q <= '0;
    else                         tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/ovl_ss_top.sv
module ovl_ss_top #(
  parameter int STEP_CYC  = 100000,
  parameter int SS_STEPS  = 8,
  parameter int OVL_TERM  = 1500,
  parameter int FMIN_BASE = 10000000,
  localparam int CODE_W   = $clog2(SS_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cyc_i,
  input  logic              ocp_end_i,
  input  logic              at_fmin_i,
  input  logic [1:0]        fopt_i,
  output logic [CODE_W-1:0] ilim_code_o,
  output logic              ss_active_o,
  output logic              trip_o
);
  logic ovl_hit, fmin_hit, trip_req, cnt_clr;

  assign trip_req = ~start_i & (ovl_hit | fmin_hit);
  assign cnt_clr  = start_i | trip_req;

  ss_ramp #(.STEP_CYC(STEP_CYC), .SS_STEPS(SS_STEPS), .CODE_W(CODE_W)) ramp_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .kill_i  (trip_req),
    .code_o  (ilim_code_o),
    .active_o(ss_active_o)
  );

  ovl_updown #(.OVL_TERM(OVL_TERM)) ovl_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (~ss_active_o),
    .cyc_i (cyc_i),
    .ocp_i (ocp_end_i),
    .hit_o (ovl_hit)
  );

  fmin_timer #(.FMIN_BASE(FMIN_BASE)) fmin_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .run_i (at_fmin_i & ~ss_active_o),
    .fopt_i(fopt_i),
    .hit_o (fmin_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trip_o <= 1'b0;
    else         trip_o <= trip_req;
  end
endmodule

// File: rtl/ovl_ss_chk.sv
module ovl_ss_chk #(
  parameter int SS_STEPS = 8,
  parameter int CODE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CODE_W-1:0] ilim_code_o,
  input logic              ss_active_o,
  input logic              trip_o
);
  // R2
  start_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ss_active_o && ilim_code_o == '0));

  // R3
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (int'(ilim_code_o) == int'($past(ilim_code_o)) ||
                  int'(ilim_code_o) == int'($past(ilim_code_o)) + 1 || trip_o));

  // R3
  code_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ilim_code_o) <= SS_STEPS);

  // R4
  no_trip_in_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_active_o |=> !trip_o);

  // R9
  trip_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> !trip_o);

  // R9
  trip_zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> (ilim_code_o == '0 && !ss_active_o));
endmodule

bind ovl_ss_top ovl_ss_chk #(.SS_STEPS(SS_STEPS), .CODE_W(CODE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ilim_code_o(ilim_code_o),
  .ss_active_o(ss_active_o),
  .trip_o     (trip_o)
);

// File: tb/ovl_ss_top_tb_top.sv
module ovl_ss_top_tb_top;
  localparam int STEP  = 4;
  localparam int STEPS = 8;
  localparam int TERM  = 6;
  localparam int BASE  = 20;
  localparam int CW    = $clog2(STEPS + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, cyc_i = 1'b0, ocp_end_i = 1'b0, at_fmin_i = 1'b0;
  logic [1:0] fopt_i = 2'd0;
  logic [CW-1:0] ilim_code_o;
  logic ss_active_o, trip_o;

  int errors = 0, checks = 0, trips = 0;
  int m_code = 0, m_ss = 0, m_trip = 0, m_tmr = 0, m_cnt = 0, m_ft = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ovl_ss_top #(.STEP_CYC(STEP), .SS_STEPS(STEPS), .OVL_TERM(TERM), .FMIN_BASE(BASE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cyc_i(cyc_i),
    .ocp_end_i(ocp_end_i), .at_fmin_i(at_fmin_i), .fopt_i(fopt_i),
    .ilim_code_o(ilim_code_o), .ss_active_o(ss_active_o), .trip_o(trip_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_code = 0; m_ss = 0; m_trip = 0; m_tmr = 0; m_cnt = 0; m_ft = 0;
    end else begin
      int thr, k;
      bit req;
      k = (fopt_i > 2) ? 2 : int'(fopt_i);
      thr = BASE << k;
      m_trip = 0;
      req = 0;
      if (start_i) begin
        m_code = 0; m_ss = 1; m_tmr = 0; m_cnt = 0; m_ft = 0;
      end else begin
        if (!m_ss) begin
          if (cyc_i) begin
            if (ocp_end_i) begin
              if (m_cnt == TERM - 1) req = 1; else m_cnt++;
            end else if (m_cnt > 0) m_cnt--;
          end
          if (at_fmin_i) begin
            if (m_ft >= thr - 1) req = 1; else m_ft++;
          end else m_ft = 0;
        end else m_ft = 0;
        if (m_ss) begin
          if (m_tmr == STEP - 1) begin
            m_tmr = 0; m_code++;
            if (m_code == STEPS) m_ss = 0;
          end else m_tmr++;
        end
        if (req) begin
          m_trip = 1; m_cnt = 0; m_ft = 0; m_code = 0; m_ss = 0; m_tmr = 0;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      chk(int'(ilim_code_o) == m_code, "R3 code", int'(ilim_code_o), m_code);
      chk(int'(ss_active_o) == m_ss, "R2 ss_active", int'(ss_active_o), m_ss);
      chk(int'(trip_o) == m_trip, "R5 trip", int'(trip_o), m_trip);
      if (trip_o) trips++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      start_i = 0; cyc_i = 0; ocp_end_i = 0;
    end
  endtask

  task automatic do_start();
    @(negedge clk_i);
    start_i = 1; cyc_i = 0; ocp_end_i = 0;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic swcyc(input bit ocp);
    @(negedge clk_i);
    cyc_i = 1; ocp_end_i = ocp;
    @(negedge clk_i);
    cyc_i = 0; ocp_end_i = 0;
  endtask

  initial begin
    int t0;
    // R1
    #1;
    chk(ilim_code_o == 0 && !ss_active_o && !trip_o, "R1 in reset", int'(ilim_code_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    idle(3);
    chk(ilim_code_o == 0 && !ss_active_o && !trip_o, "R1 after release", int'(ilim_code_o), 0);

    // R2 R3: full ramp
    do_start();
    chk(ss_active_o && ilim_code_o == 0, "R2 start", int'(ss_active_o), 1);
    idle(STEP * STEPS + 4);
    chk(int'(ilim_code_o) == STEPS && !ss_active_o, "R3 full scale", int'(ilim_code_o), STEPS);

    // R4: overcurrent and fmin during ramp are ignored
    trips = 0;
    do_start();
    at_fmin_i = 1;
    for (int i = 0; i < (STEP * STEPS) / 2 - 2; i++) swcyc(1);
    at_fmin_i = 0;
    chk(trips == 0, "R4 no trip during soft-start", trips, 0);
    idle(6);
    for (int i = 0; i < TERM - 1; i++) swcyc(1);
    chk(trips == 0, "R4 counter held during ramp", trips, 0);
    swcyc(1);
    idle(1);
    // R5 R9
    chk(trips == 1, "R5 trip at end of count", trips, 1);
    chk(ilim_code_o == 0 && !ss_active_o, "R9 code zero after trip", int'(ilim_code_o), 0);

    // R6: intermittent decays, saturation at zero
    do_start();
    idle(STEP * STEPS + 2);
    trips = 0;
    for (int i = 0; i < 30; i++) begin swcyc(1); swcyc(0); end
    for (int i = 0; i < 20; i++) swcyc(0);
    for (int i = 0; i < TERM - 1; i++) swcyc(1);
    chk(trips == 0, "R6 intermittent no trip", trips, 0);
    swcyc(1);
    idle(1);
    chk(trips == 1, "R6 trip after full count from zero", trips, 1);

    // R10: start clears partial count
    do_start();
    idle(STEP * STEPS + 2);
    trips = 0;
    for (int i = 0; i < TERM - 1; i++) swcyc(1);
    do_start();
    idle(STEP * STEPS + 2);
    for (int i = 0; i < TERM - 1; i++) swcyc(1);
    chk(trips == 0, "R10 start clears counter", trips, 0);

    // R7: min-frequency delay per option
    for (int k = 0; k < 4; k++) begin
      int exp_d;
      exp_d = BASE << ((k > 2) ? 2 : k);
      do_start();
      idle(STEP * STEPS + 2);
      trips = 0;
      @(negedge clk_i);
      fopt_i = 2'(k); at_fmin_i = 1;
      t0 = 0;
      while (!trip_o && t0 < 200) begin @(negedge clk_i); t0++; end
      at_fmin_i = 0;
      chk(t0 == exp_d, "R7 fmin delay", t0, exp_d);
    end

    // R8: dropping flag clears timer
    fopt_i = 2'd0;
    do_start();
    idle(STEP * STEPS + 2);
    trips = 0;
    @(negedge clk_i); at_fmin_i = 1;
    idle(BASE - 3);
    @(negedge clk_i); at_fmin_i = 0;
    @(negedge clk_i); at_fmin_i = 1;
    idle(BASE - 3);
    @(negedge clk_i); at_fmin_i = 0;
    idle(2);
    chk(trips == 0, "R8 flag drop clears timer", trips, 0);

    // R9: single-clock pulse
    @(negedge clk_i); at_fmin_i = 1;
    idle(BASE + 2);
    at_fmin_i = 0;
    chk(trips == 1, "R9 single pulse", trips, 1);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule